// File: doc/BRIEF.md
# Splittable Up-Counter with Gated Match Reload

The block is a free-running up-counter of two halves that can run either as two independent counters (the low half and the high half, each with its own enable and wrap limit) or as one counter twice as wide, where the low half carries into the high half. Each half owns a small bank of match registers. The match registers are not written directly. They are refreshed from a bank of shadow reload registers on the clock edge where the counter, or its half, wraps from its limit back to zero. Two inhibit inputs can block that refresh, so software can change the reload values over several cycles without a half-updated set taking effect.

A compare output per match register asserts in every cycle in which counting is enabled and the count equals that match register. In the wide mode, each compare spans both halves: low match register k and high match register k form one wide value, its result appears on the low compare output k, and the high compare outputs stay at 0. The mode input is sampled only when the counter is cleared, either by reset or by the synchronous clear input. A mode change therefore never produces a count that mixes both modes.

Limit and reload values are loaded through a plain single-cycle write port. These are control registers, not a data stream, so the port has no handshake and is never back-pressured. A write is visible from the next cycle.

Top module: `splitcnt`

## Requirements
- R1: After reset, both counts, both limits, every reload register and every match register are 0, and the block is in split mode (unify treated as 0). The first enabled cycle after reset therefore shows every low compare output at 1.
- R2: In split mode, with `en_lo_i` high, the low count steps by one per cycle and goes from `lim_lo` to 0. With `en_lo_i` low, the low count holds. This applies for every limit value, including 0 and all-ones.
- R3: In split mode, the high count behaves like R2 using `en_hi_i` and `lim_hi`, independently of the low half.
- R4: In joined mode, the count {`cnt_hi_o`,`cnt_lo_o`} is one up-counter of width 2*HALF_W. The low half carries into the high half. The counter advances only with `en_lo_i` and goes to 0 after reaching {`lim_hi`,`lim_lo`}. `en_hi_i` is ignored.
- R5: A compare output is 1 exactly when the count it watches equals its match register and its counting enable is high. In split mode each half uses its own count and enable. In joined mode, `match_lo_o[k]` compares the full count with {match_hi[k], match_lo[k]} under `en_lo_i`, and `match_hi_o` is all 0.
- R6: On a wrap edge, every match register of the wrapping half takes its reload register's value. A wrap in joined mode reloads both halves. The new value is compared from the next cycle on, which is the cycle in which the count reads 0.
- R7: In split mode, `noreload_lo_i` = 1 leaves the low match registers unchanged at a low wrap, and `noreload_hi_i` = 1 leaves the high match registers unchanged at a high wrap.
- R8: In joined mode, `noreload_lo_i` = 1 blocks the reload of both banks, and `noreload_hi_i` has no effect.
- R9: `unify_i` (0 = split, 1 = joined) is taken in only on reset or on a cycle with `clr_i` = 1. That cycle also sets both counts to 0 and performs no reload. A change of `unify_i` at any other time has no effect.
- R10: With `wr_en_i` = 1, `wr_limit_i` selects the target (1 = limit register, 0 = reload register `wr_idx_i`) and `wr_hi_i` selects the half (1 = high). The value `wr_data_i` is stored at the clock edge. A reload that happens on the same edge uses the value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of both halves; latches the mode |
| unify_i | input | 1 | Requested mode: 0 split, 1 joined |
| noreload_lo_i | input | 1 | Block reload of low match registers (both banks in joined mode) |
| noreload_hi_i | input | 1 | Block reload of high match registers (split mode only) |
| en_lo_i | input | 1 | Count enable, low half (whole counter when joined) |
| en_hi_i | input | 1 | Count enable, high half (split mode only) |
| wr_en_i | input | 1 | Register write strobe |
| wr_limit_i | input | 1 | Write target: 1 limit, 0 reload register |
| wr_hi_i | input | 1 | Write half: 1 high, 0 low |
| wr_idx_i | input | IDX_W | Reload register index |
| wr_data_i | input | HALF_W | Write value |
| cnt_lo_o | output | HALF_W | Low half count |
| cnt_hi_o | output | HALF_W | High half count |
| match_lo_o | output | N_MATCH | Low compare outputs (wide compares in joined mode) |
| match_hi_o | output | N_MATCH | High compare outputs (0 in joined mode) |

## Verification
The bench runs a narrow instance and sweeps every low and high limit value, plus a grid of wide limits. This exposes a counter that wraps one step early or late, or that fails to wrap at all-ones. It flips `unify_i` without a clear and checks that the counting still follows the old mode. A design that switched mode immediately would mix carry behaviour in the middle of a count. It sets each inhibit in each mode while the reload registers hold new values. This catches a design that lets the high inhibit act in joined mode, or that ignores the low inhibit for the high bank. It also catches reload timing errors: a design that loads on the wrong edge, or uses the value written on the same edge, fails to produce the compare pulse where the count reads 0.

// File: rtl/splitcnt_pkg.sv
package splitcnt_pkg;
  typedef enum logic {
    MODE_SPLIT  = 1'b0,
    MODE_JOINED = 1'b1
  } cnt_mode_e;

  typedef enum logic {
    WR_RELOAD = 1'b0,
    WR_LIMIT  = 1'b1
  } wr_kind_e;
endpackage

// File: rtl/splitcnt_regs.sv
module splitcnt_regs
  import splitcnt_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int N_MATCH = 4,
  parameter int IDX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic                            wr_limit_i,
  input  logic                            wr_hi_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [HALF_W-1:0]               wr_data_i,
  output logic [HALF_W-1:0]               lim_lo_o,
  output logic [HALF_W-1:0]               lim_hi_o,
  output logic [N_MATCH-1:0][HALF_W-1:0]  rld_lo_o,
  output logic [N_MATCH-1:0][HALF_W-1:0]  rld_hi_o
);
  wr_kind_e kind;
  assign kind = wr_kind_e'(wr_limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_lo_o <= '0;
      lim_hi_o <= '0;
    end else if (wr_en_i && kind == WR_LIMIT) begin
      if (wr_hi_i) lim_hi_o <= wr_data_i;
      else         lim_lo_o <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_lo_o <= '0;
      rld_hi_o <= '0;
    end else if (wr_en_i && kind == WR_RELOAD) begin
      for (int k = 0; k < N_MATCH; k++) begin
        if (wr_idx_i == IDX_W'(k)) begin
          if (wr_hi_i) rld_hi_o[k] <= wr_data_i;
          else         rld_lo_o[k] <= wr_data_i;
        end
      end
    end
  end
endmodule

// File: rtl/splitcnt_core.sv
module splitcnt_core
  import splitcnt_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              unify_i,
  input  logic              en_lo_i,
  input  logic              en_hi_i,
  input  logic [HALF_W-1:0] lim_lo_i,
  input  logic [HALF_W-1:0] lim_hi_i,
  output logic [HALF_W-1:0] cnt_lo_o,
  output logic [HALF_W-1:0] cnt_hi_o,
  output logic              wrap_lo_o,
  output logic              wrap_hi_o,
  output cnt_mode_e         mode_o
);
  localparam int FULL_W = 2 * HALF_W;

  cnt_mode_e          mode_q;
  logic [HALF_W-1:0]  cnt_lo_q, cnt_hi_q;
  logic [FULL_W-1:0]  cnt_full, lim_full, full_next;
  logic               full_at_lim, lo_at_lim, hi_at_lim;
  logic               joined;

  assign joined      = (mode_q == MODE_JOINED);
  assign cnt_full    = {cnt_hi_q, cnt_lo_q};
  assign lim_full    = {lim_hi_i, lim_lo_i};
  assign full_at_lim = (cnt_full == lim_full);
  assign lo_at_lim   = (cnt_lo_q == lim_lo_i);
  assign hi_at_lim   = (cnt_hi_q == lim_hi_i);
  assign full_next   = full_at_lim ? '0 : cnt_full + FULL_W'(1);

  always_comb begin
    if (clr_i) begin
      wrap_lo_o = 1'b0;
      wrap_hi_o = 1'b0;
    end else if (joined) begin
      wrap_lo_o = en_lo_i && full_at_lim;
      wrap_hi_o = en_lo_i && full_at_lim;
    end else begin
      wrap_lo_o = en_lo_i && lo_at_lim;
      wrap_hi_o = en_hi_i && hi_at_lim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SPLIT;
    end else if (clr_i) begin
      mode_q <= cnt_mode_e'(unify_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
    end else if (clr_i) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
    end else if (joined) begin
      if (en_lo_i) {cnt_hi_q, cnt_lo_q} <= full_next;
    end else begin
      if (en_lo_i) cnt_lo_q <= lo_at_lim ? '0 : cnt_lo_q + HALF_W'(1);
      if (en_hi_i) cnt_hi_q <= hi_at_lim ? '0 : cnt_hi_q + HALF_W'(1);
    end
  end

  assign cnt_lo_o = cnt_lo_q;
  assign cnt_hi_o = cnt_hi_q;
  assign mode_o   = mode_q;

  // R9: mode only moves on a clear
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> $stable(mode_q));

  // R2: split low half returns to zero after its limit
  a_r2_lo_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!joined && !clr_i && en_lo_i && cnt_lo_q == lim_lo_i) |=> (cnt_lo_q == '0));

  // R2/R3: nothing enabled, nothing moves
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_lo_i && (joined || !en_hi_i)) |=> ($stable(cnt_lo_q) && $stable(cnt_hi_q)));

  // R4: joined low half carries into the high half
  a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && !clr_i && en_lo_i && !full_at_lim && cnt_lo_q == '1)
      |=> (cnt_lo_q == '0 && cnt_hi_q == $past(cnt_hi_q) + HALF_W'(1)));
endmodule

// File: rtl/splitcnt_match.sv
module splitcnt_match
  import splitcnt_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int N_MATCH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  cnt_mode_e                      mode_i,
  input  logic                           noreload_lo_i,
  input  logic                           noreload_hi_i,
  input  logic                           wrap_lo_i,
  input  logic                           wrap_hi_i,
  input  logic [N_MATCH-1:0][HALF_W-1:0] rld_lo_i,
  input  logic [N_MATCH-1:0][HALF_W-1:0] rld_hi_i,
  input  logic [HALF_W-1:0]              cnt_lo_i,
  input  logic [HALF_W-1:0]              cnt_hi_i,
  input  logic                           en_lo_i,
  input  logic                           en_hi_i,
  output logic [N_MATCH-1:0]             match_lo_o,
  output logic [N_MATCH-1:0]             match_hi_o
);
  logic [N_MATCH-1:0][HALF_W-1:0] mt_lo_q, mt_hi_q;
  logic joined, load_lo, load_hi, block_hi;

  assign joined   = (mode_i == MODE_JOINED);
  assign block_hi = joined ? noreload_lo_i : noreload_hi_i;
  assign load_lo  = wrap_lo_i && !noreload_lo_i;
  assign load_hi  = wrap_hi_i && !block_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mt_lo_q <= '0;
      mt_hi_q <= '0;
    end else begin
      if (load_lo) mt_lo_q <= rld_lo_i;
      if (load_hi) mt_hi_q <= rld_hi_i;
    end
  end

  for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
    always_comb begin
      if (joined) begin
        match_lo_o[k] = en_lo_i && ({cnt_hi_i, cnt_lo_i} == {mt_hi_q[k], mt_lo_q[k]});
        match_hi_o[k] = 1'b0;
      end else begin
        match_lo_o[k] = en_lo_i && (cnt_lo_i == mt_lo_q[k]);
        match_hi_o[k] = en_hi_i && (cnt_hi_i == mt_hi_q[k]);
      end
    end
  end

  // R7/R8: low inhibit freezes the low bank in both modes
  a_r7_lo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    noreload_lo_i |=> $stable(mt_lo_q));

  // R7: split high inhibit freezes the high bank
  a_r7_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!joined && noreload_hi_i) |=> $stable(mt_hi_q));

  // R8: joined low inhibit also freezes the high bank
  a_r8_joined_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && noreload_lo_i) |=> $stable(mt_hi_q));
endmodule

// File: rtl/splitcnt.sv
module splitcnt
  import splitcnt_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int N_MATCH = 4,
  parameter int IDX_W   = (N_MATCH > 1) ? $clog2(N_MATCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               unify_i,
  input  logic               noreload_lo_i,
  input  logic               noreload_hi_i,
  input  logic               en_lo_i,
  input  logic               en_hi_i,
  input  logic               wr_en_i,
  input  logic               wr_limit_i,
  input  logic               wr_hi_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [HALF_W-1:0]  wr_data_i,
  output logic [HALF_W-1:0]  cnt_lo_o,
  output logic [HALF_W-1:0]  cnt_hi_o,
  output logic [N_MATCH-1:0] match_lo_o,
  output logic [N_MATCH-1:0] match_hi_o
);
  logic [HALF_W-1:0]              lim_lo, lim_hi;
  logic [N_MATCH-1:0][HALF_W-1:0] rld_lo, rld_hi;
  logic                           wrap_lo, wrap_hi;
  cnt_mode_e                      mode;

  splitcnt_regs #(.HALF_W(HALF_W), .N_MATCH(N_MATCH), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_limit_i (wr_limit_i),
    .wr_hi_i    (wr_hi_i),
    .wr_idx_i   (wr_idx_i),
    .wr_data_i  (wr_data_i),
    .lim_lo_o   (lim_lo),
    .lim_hi_o   (lim_hi),
    .rld_lo_o   (rld_lo),
    .rld_hi_o   (rld_hi)
  );

  splitcnt_core #(.HALF_W(HALF_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .unify_i   (unify_i),
    .en_lo_i   (en_lo_i),
    .en_hi_i   (en_hi_i),
    .lim_lo_i  (lim_lo),
    .lim_hi_i  (lim_hi),
    .cnt_lo_o  (cnt_lo_o),
    .cnt_hi_o  (cnt_hi_o),
    .wrap_lo_o (wrap_lo),
    .wrap_hi_o (wrap_hi),
    .mode_o    (mode)
  );

  splitcnt_match #(.HALF_W(HALF_W), .N_MATCH(N_MATCH)) u_match (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode),
    .noreload_lo_i (noreload_lo_i),
    .noreload_hi_i (noreload_hi_i),
    .wrap_lo_i     (wrap_lo),
    .wrap_hi_i     (wrap_hi),
    .rld_lo_i      (rld_lo),
    .rld_hi_i      (rld_hi),
    .cnt_lo_i      (cnt_lo_o),
    .cnt_hi_i      (cnt_hi_o),
    .en_lo_i       (en_lo_i),
    .en_hi_i       (en_hi_i),
    .match_lo_o    (match_lo_o),
    .match_hi_o    (match_hi_o)
  );
endmodule

// File: tb/splitcnt_tb_top.sv
module splitcnt_tb_top;
  localparam int HW = 4;
  localparam int NM = 2;
  localparam int IW = 1;
  localparam int HMAX = 1 << HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 0, unify_i = 0, noreload_lo_i = 0, noreload_hi_i = 0;
  logic en_lo_i = 0, en_hi_i = 0;
  logic wr_en_i = 0, wr_limit_i = 0, wr_hi_i = 0;
  logic [IW-1:0] wr_idx_i = '0;
  logic [HW-1:0] wr_data_i = '0;
  logic [HW-1:0] cnt_lo_o, cnt_hi_o;
  logic [NM-1:0] match_lo_o, match_hi_o;

  int errors = 0;
  int checks = 0;

  int m_lo = 0, m_hi = 0, m_mode = 0;
  int m_lim_lo = 0, m_lim_hi = 0;
  int m_rld_lo [NM];
  int m_rld_hi [NM];
  int m_mt_lo [NM];
  int m_mt_hi [NM];

  always #2 clk = ~clk;

  splitcnt #(.HALF_W(HW), .N_MATCH(NM), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .unify_i(unify_i),
    .noreload_lo_i(noreload_lo_i), .noreload_hi_i(noreload_hi_i),
    .en_lo_i(en_lo_i), .en_hi_i(en_hi_i),
    .wr_en_i(wr_en_i), .wr_limit_i(wr_limit_i), .wr_hi_i(wr_hi_i),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o),
    .match_lo_o(match_lo_o), .match_hi_o(match_hi_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: check outputs, then advance the reference model at the edge
  task automatic cycle(string tag);
    logic [NM-1:0] eml, emh;
    int full, lim, n_lo, n_hi;
    bit rl_lo, rl_hi;
    #1;
    full = m_hi * HMAX + m_lo;
    for (int k = 0; k < NM; k++) begin
      if (m_mode == 1) begin
        eml[k] = en_lo_i && (full == m_mt_hi[k] * HMAX + m_mt_lo[k]);
        emh[k] = 1'b0;
      end else begin
        eml[k] = en_lo_i && (m_lo == m_mt_lo[k]);
        emh[k] = en_hi_i && (m_hi == m_mt_hi[k]);
      end
    end
    chk(tag, "cnt_lo", int'(cnt_lo_o), m_lo);
    chk(tag, "cnt_hi", int'(cnt_hi_o), m_hi);
    chk(tag, "match_lo", int'(match_lo_o), int'(eml));
    chk(tag, "match_hi", int'(match_hi_o), int'(emh));
    n_lo = m_lo; n_hi = m_hi; rl_lo = 0; rl_hi = 0;
    lim = m_lim_hi * HMAX + m_lim_lo;
    if (clr_i) begin
      n_lo = 0; n_hi = 0;
    end else if (m_mode == 1) begin
      if (en_lo_i) begin
        if (full == lim) begin
          full = 0;
          rl_lo = !noreload_lo_i; rl_hi = !noreload_lo_i;
        end else full = full + 1;
        n_lo = full % HMAX; n_hi = full / HMAX;
      end
    end else begin
      if (en_lo_i) begin
        if (m_lo == m_lim_lo) begin n_lo = 0; rl_lo = !noreload_lo_i; end
        else n_lo = m_lo + 1;
      end
      if (en_hi_i) begin
        if (m_hi == m_lim_hi) begin n_hi = 0; rl_hi = !noreload_hi_i; end
        else n_hi = m_hi + 1;
      end
    end
    @(posedge clk);
    for (int k = 0; k < NM; k++) begin
      if (rl_lo) m_mt_lo[k] = m_rld_lo[k];
      if (rl_hi) m_mt_hi[k] = m_rld_hi[k];
    end
    if (clr_i) m_mode = int'(unify_i);
    if (wr_en_i) begin
      if (wr_limit_i) begin
        if (wr_hi_i) m_lim_hi = int'(wr_data_i); else m_lim_lo = int'(wr_data_i);
      end else begin
        if (wr_hi_i) m_rld_hi[wr_idx_i] = int'(wr_data_i);
        else         m_rld_lo[wr_idx_i] = int'(wr_data_i);
      end
    end
    m_lo = n_lo; m_hi = n_hi;
    @(negedge clk);
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic wr(string tag, bit lim, bit hi, int idx, int data);
    wr_en_i = 1; wr_limit_i = lim; wr_hi_i = hi;
    wr_idx_i = IW'(idx); wr_data_i = HW'(data);
    cycle(tag);
    wr_en_i = 0;
  endtask

  task automatic clear(string tag);
    clr_i = 1;
    cycle(tag);
    clr_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NM; k++) begin
      m_rld_lo[k] = 0; m_rld_hi[k] = 0; m_mt_lo[k] = 0; m_mt_hi[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset values, zero limit, zero match registers
    en_lo_i = 1; en_hi_i = 1;
    run("R1", 3);
    en_lo_i = 0; en_hi_i = 0;

    // R10: program limits and reloads while idle
    wr("R10", 1, 0, 0, 5);
    wr("R10", 1, 1, 0, 3);
    wr("R10", 0, 0, 0, 2);
    wr("R10", 0, 0, 1, 4);
    wr("R10", 0, 1, 0, 1);
    wr("R10", 0, 1, 1, 3);
    run("R10", 2);

    // R2 R3 R5 R6: split counting with irregular high enable
    for (int i = 0; i < 40; i++) begin
      en_lo_i = (i % 7) != 3;
      en_hi_i = (i % 3) != 0;
      cycle("R2 R3 R5 R6");
    end

    // R2: sweep every low limit
    en_hi_i = 0;
    for (int l = 0; l < HMAX; l++) begin
      en_lo_i = 0;
      wr("R2", 1, 0, 0, l);
      clear("R2");
      en_lo_i = 1;
      run("R2", l + 3);
    end

    // R3: sweep every high limit
    en_lo_i = 0;
    for (int l = 0; l < HMAX; l++) begin
      en_hi_i = 0;
      wr("R3", 1, 1, 0, l);
      clear("R3");
      en_hi_i = 1;
      run("R3", l + 3);
    end

    // R7: inhibit each half in split mode while new reloads wait
    wr("R7", 1, 0, 0, 5);
    wr("R7", 1, 1, 0, 4);
    en_lo_i = 1; en_hi_i = 1;
    noreload_lo_i = 1;
    wr("R7", 0, 0, 0, 3);
    wr("R7", 0, 0, 1, 0);
    run("R7", 15);
    noreload_lo_i = 0; noreload_hi_i = 1;
    wr("R7", 0, 1, 0, 2);
    wr("R7", 0, 1, 1, 4);
    run("R7", 15);
    noreload_hi_i = 0;
    run("R7 R6", 12);

    // R9: unify request without clear keeps split counting
    unify_i = 1;
    run("R9", 12);
    clear("R9");
    unify_i = 0;
    run("R9", 40);
    unify_i = 1;

    // R4 R5 R6: joined counting, high enable toggling
    en_lo_i = 0;
    wr("R4", 1, 0, 0, 15);
    wr("R4", 1, 1, 0, 2);
    wr("R4", 0, 0, 0, 9);
    wr("R4", 0, 1, 0, 1);
    wr("R4", 0, 0, 1, 0);
    wr("R4", 0, 1, 1, 2);
    clear("R4");
    for (int i = 0; i < 120; i++) begin
      en_lo_i = (i % 11) != 5;
      en_hi_i = (i % 2) == 0;
      cycle("R4 R5 R6");
    end

    // R4: joined limit grid
    for (int lh = 0; lh < 4; lh++) begin
      for (int s = 0; s < 3; s++) begin
        en_lo_i = 0;
        wr("R4", 1, 1, 0, lh);
        wr("R4", 1, 0, 0, (s == 0) ? 0 : ((s == 1) ? 7 : 15));
        clear("R4");
        en_lo_i = 1;
        run("R4", lh * HMAX + 18);
      end
    end

    // R8: high inhibit ignored when joined, low inhibit blocks both
    wr("R8", 1, 1, 0, 1);
    wr("R8", 1, 0, 0, 10);
    noreload_hi_i = 1;
    wr("R8", 0, 0, 0, 6);
    wr("R8", 0, 1, 0, 1);
    run("R8", 40);
    noreload_hi_i = 0; noreload_lo_i = 1;
    wr("R8", 0, 0, 0, 2);
    wr("R8", 0, 1, 0, 0);
    wr("R8", 0, 0, 1, 8);
    wr("R8", 0, 1, 1, 1);
    run("R8", 40);
    noreload_lo_i = 0;
    run("R8 R6", 40);

    // R9: back to split through a clear
    unify_i = 0;
    clear("R9");
    en_hi_i = 1;
    run("R9", 30);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule